// File: doc/BRIEF.md
# Tagged Access Check Qualifier

This unit sits beside the load/store pipeline and, for every memory access it is handed, decides whether that access must be compared against its memory tag. It works out the effective privilege and virtualization of the access and picks the tag-mode field that governs it. It then applies the suppression rules for hypervisor virtual-machine loads/stores, for loads that only read instruction encodings, and for accesses made under machine-mode privilege modification. When a checked access reports a tag mismatch, the unit raises a synchronous software-check exception. It also tells the status logic when to write the code-page tag flag and with which value, that value being the AND of the leaf PTE's MTAG and execute bits. The page walker and the tag storage are outside this block.

All results are registered. The outputs describe the access presented in the previous cycle. A small state machine records the outcome of that access: `ST_IDLE` means no access, `ST_PASS` means an access with no exception, and `ST_FAULT` means an access that raised the exception. From any state the next state is `ST_FAULT` when a valid, checked access reports a mismatch, `ST_PASS` for any other valid access, and `ST_IDLE` when no access is presented. Reset forces `ST_IDLE`.

Top module: `tagchk_qual`

## Requirements
- R1: An access of kind 4 (instruction-reading hypervisor load) is never checked. For it `hflag_we` is 1 and `flag_val` equals `pte_mtag & pte_x`. Kind codes: 0 load, 1 store, 2 hypervisor load, 3 hypervisor store, 4 instruction-reading hypervisor load.
- R2: A hypervisor load or store (kind 2 or 3) is unchecked when `pte_x` is 1.
- R3: A hypervisor load or store is unchecked when `hstat[10]` (the guest code-page tag flag) is 1. Otherwise it runs with effective virtualization 1 and effective privilege S if `hstat[8]` is 1, U if it is 0. It uses `mode_vs` for effective S.
- R4: Privilege modification is active only when `cur_priv` is M and `mstat[17]` is 1. The effective privilege is then `mstat[12:11]`, and the effective virtualization is `mstat[39]` unless that privilege is M. While it is active, a load (kind 0) with `pte_x` set is unchecked.
- R5: While privilege modification is active and `mstat[40]` is 1, loads and stores are unchecked. A load made while it is active with `mstat[19]` set raises `mflag_we`, with `flag_val` = `pte_mtag & pte_x`.
- R6: A hypervisor access with effective privilege U, issued from U with `cur_virt`=0, takes its mode from `hstat[51:50]`. The same access issued from S takes `mode_vu`.
- R7: Any other access takes its mode from the current privilege: `mode_m`, `mode_s`, `mode_u`, or `mode_vs`/`mode_vu` when `cur_virt` is 1. Privilege codes are U=0, S=1, M=3; code 2 selects mode 00. An access whose selected mode is 00 is unchecked.
- R8: A valid, checked access with `tag_mismatch`=1 raises `xcpt_valid` with cause 18 and tval 4. `xcpt_gva` equals the effective virtualization, which is always 1 for hypervisor accesses.
- R9: Outputs show the access of the previous cycle. The exception lasts exactly one cycle per faulting access. When no access was presented, all outputs are 0.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 3 | Access kind code |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| cur_virt | input | 1 | Current virtualization state |
| mstat | input | XLEN | Machine status word |
| hstat | input | XLEN | Hypervisor status word |
| pte_x | input | 1 | Leaf PTE execute permission |
| pte_mtag | input | 1 | Leaf PTE MTAG bit |
| mode_m | input | 2 | Tag mode for M |
| mode_s | input | 2 | Tag mode for S/HS |
| mode_u | input | 2 | Tag mode for U/HU |
| mode_vs | input | 2 | Tag mode for VS |
| mode_vu | input | 2 | Tag mode for VU |
| tag_mismatch | input | 1 | Tag compare failed for this access |
| out_valid | output | 1 | Result describes an access |
| out_checked | output | 1 | Access is tag-checked |
| out_mode | output | 2 | Selected tag mode |
| xcpt_valid | output | 1 | Software-check exception |
| xcpt_cause | output | XLEN | Exception cause |
| xcpt_tval | output | XLEN | Exception tval |
| xcpt_gva | output | 1 | Guest virtual address flag |
| hflag_we | output | 1 | Write guest code-page tag flag |
| mflag_we | output | 1 | Write machine code-page tag flag |
| flag_val | output | 1 | Value for the flag write |

## Verification
The bench targets the places where several suppression rules meet. The first is a hypervisor access with an executable leaf; a design that ignored `pte_x` there would raise spurious exceptions on guest code pages. The second is a store under privilege modification with an executable leaf; it must stay checked, and a design that applied the load-only rule to stores would silently skip the check. The bench also exercises privilege modification outside M mode and the U-issued versus S-issued guest user access. Faulty mode selection in either of these cases shows up as a wrong `out_mode`. Back-to-back mismatches must give one exception per access and not a stretched or lost pulse.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    typedef enum logic [2:0] {
        K_LOAD  = 3'd0,
        K_STORE = 3'd1,
        K_HLD   = 3'd2,
        K_HST   = 3'd3,
        K_HLDX  = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_FAULT = 2'd2
    } qual_state_e;

    localparam int SWCHK_CAUSE   = 18;
    localparam int MISMATCH_TVAL = 4;

    // status word bit positions that neighbouring CSR logic also decodes
    localparam int MS_MPRV  = 17;
    localparam int MS_MXR   = 19;
    localparam int MS_MPP_L = 11;
    localparam int MS_MPV   = 39;
    localparam int MS_CFLAG = 40;
    localparam int HS_SPVP  = 8;
    localparam int HS_CFLAG = 10;
    localparam int HS_VUM_L = 50;
endpackage

// File: rtl/tagchk_privsel.sv
module tagchk_privsel
    import tagchk_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2:0]      kind,
    input  logic [1:0]      cur_priv,
    input  logic            cur_virt,
    input  logic [XLEN-1:0] mstat,
    input  logic [XLEN-1:0] hstat,
    input  logic [1:0]      mode_m,
    input  logic [1:0]      mode_s,
    input  logic [1:0]      mode_u,
    input  logic [1:0]      mode_vs,
    input  logic [1:0]      mode_vu,
    output logic            is_hyp,
    output logic            mod_act,
    output logic            eff_virt,
    output logic [1:0]      sel_mode
);
    logic [1:0] eff_priv;
    logic       from_hu;

    always_comb begin
        is_hyp   = (kind == K_HLD) || (kind == K_HST) || (kind == K_HLDX);
        mod_act  = !is_hyp && (cur_priv == PRIV_M) && mstat[MS_MPRV];
        from_hu  = (cur_priv == PRIV_U) && !cur_virt;
        if (is_hyp) begin
            eff_virt = 1'b1;
            eff_priv = hstat[HS_SPVP] ? PRIV_S : PRIV_U;
        end else if (mod_act) begin
            eff_priv = mstat[MS_MPP_L+1:MS_MPP_L];
            eff_virt = mstat[MS_MPV] && (eff_priv != PRIV_M);
        end else begin
            eff_priv = cur_priv;
            eff_virt = cur_virt;
        end
        sel_mode = 2'b00;
        if (eff_virt) begin
            unique case (eff_priv)
                PRIV_S:  sel_mode = mode_vs;
                PRIV_U:  sel_mode = (is_hyp && from_hu) ? hstat[HS_VUM_L+1:HS_VUM_L] : mode_vu;
                default: sel_mode = 2'b00;
            endcase
        end else begin
            unique case (eff_priv)
                PRIV_M:  sel_mode = mode_m;
                PRIV_S:  sel_mode = mode_s;
                PRIV_U:  sel_mode = mode_u;
                default: sel_mode = 2'b00;
            endcase
        end
    end
endmodule

// File: rtl/tagchk_gate.sv
module tagchk_gate
    import tagchk_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] kind,
    input  logic       is_hyp,
    input  logic       mod_act,
    input  logic       pte_x,
    input  logic       h_cflag,
    input  logic       m_cflag,
    input  logic [1:0] sel_mode,
    output logic       checked
);
    logic suppress;

    always_comb begin
        suppress = 1'b0;
        if (kind == K_HLDX)
            suppress = 1'b1;
        else if (is_hyp && (pte_x || h_cflag))
            suppress = 1'b1;
        else if (mod_act && m_cflag && (kind == K_LOAD || kind == K_STORE))
            suppress = 1'b1;
        else if (mod_act && pte_x && kind == K_LOAD)
            suppress = 1'b1;
        checked = valid && !suppress && (sel_mode != 2'b00) && (kind <= K_HLDX);
    end
endmodule

// File: rtl/tagchk_qual.sv
module tagchk_qual
    import tagchk_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [2:0]      acc_kind,
    input  logic [1:0]      cur_priv,
    input  logic            cur_virt,
    input  logic [XLEN-1:0] mstat,
    input  logic [XLEN-1:0] hstat,
    input  logic            pte_x,
    input  logic            pte_mtag,
    input  logic [1:0]      mode_m,
    input  logic [1:0]      mode_s,
    input  logic [1:0]      mode_u,
    input  logic [1:0]      mode_vs,
    input  logic [1:0]      mode_vu,
    input  logic            tag_mismatch,
    output logic            out_valid,
    output logic            out_checked,
    output logic [1:0]      out_mode,
    output logic            xcpt_valid,
    output logic [XLEN-1:0] xcpt_cause,
    output logic [XLEN-1:0] xcpt_tval,
    output logic            xcpt_gva,
    output logic            hflag_we,
    output logic            mflag_we,
    output logic            flag_val
);
    logic        is_hyp, mod_act, eff_virt, chk_c;
    logic [1:0]  mode_c;
    qual_state_e state_q, state_d;
    logic        chk_q, gva_q, hwe_q, mwe_q, fval_q;
    logic [1:0]  mode_q;

    tagchk_privsel #(.XLEN(XLEN)) u_sel (
        .kind(acc_kind), .cur_priv(cur_priv), .cur_virt(cur_virt),
        .mstat(mstat), .hstat(hstat),
        .mode_m(mode_m), .mode_s(mode_s), .mode_u(mode_u),
        .mode_vs(mode_vs), .mode_vu(mode_vu),
        .is_hyp(is_hyp), .mod_act(mod_act), .eff_virt(eff_virt), .sel_mode(mode_c)
    );

    tagchk_gate u_gate (
        .valid(acc_valid), .kind(acc_kind), .is_hyp(is_hyp), .mod_act(mod_act),
        .pte_x(pte_x), .h_cflag(hstat[HS_CFLAG]), .m_cflag(mstat[MS_CFLAG]),
        .sel_mode(mode_c), .checked(chk_c)
    );

    always_comb begin
        if (!acc_valid)
            state_d = ST_IDLE;
        else if (chk_c && tag_mismatch)
            state_d = ST_FAULT;
        else
            state_d = ST_PASS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            chk_q   <= 1'b0;
            mode_q  <= 2'b00;
            gva_q   <= 1'b0;
            hwe_q   <= 1'b0;
            mwe_q   <= 1'b0;
            fval_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            chk_q   <= chk_c;
            mode_q  <= acc_valid ? mode_c : 2'b00;
            gva_q   <= eff_virt;
            hwe_q   <= acc_valid && (acc_kind == K_HLDX);
            mwe_q   <= acc_valid && mod_act && mstat[MS_MXR] && (acc_kind == K_LOAD);
            fval_q  <= pte_mtag && pte_x;
        end
    end

    always_comb begin
        out_valid   = 1'b0;
        out_checked = 1'b0;
        out_mode    = 2'b00;
        xcpt_valid  = 1'b0;
        xcpt_cause  = '0;
        xcpt_tval   = '0;
        xcpt_gva    = 1'b0;
        hflag_we    = 1'b0;
        mflag_we    = 1'b0;
        flag_val    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PASS, ST_FAULT: begin
                out_valid   = 1'b1;
                out_checked = chk_q;
                out_mode    = mode_q;
                hflag_we    = hwe_q;
                mflag_we    = mwe_q;
                flag_val    = (hwe_q || mwe_q) && fval_q;
                if (state_q == ST_FAULT) begin
                    xcpt_valid = 1'b1;
                    xcpt_cause = XLEN'(SWCHK_CAUSE);
                    xcpt_tval  = XLEN'(MISMATCH_TVAL);
                    xcpt_gva   = gva_q;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tagchk_qual_chk.sv
module tagchk_qual_chk
    import tagchk_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic [2:0]      acc_kind,
    input logic [1:0]      cur_priv,
    input logic            cur_virt,
    input logic [XLEN-1:0] mstat,
    input logic [XLEN-1:0] hstat,
    input logic            pte_x,
    input logic            tag_mismatch,
    input logic            out_valid,
    input logic            out_checked,
    input logic [1:0]      out_mode,
    input logic            xcpt_valid,
    input logic [XLEN-1:0] xcpt_tval,
    input logic            xcpt_gva
);
    AST_HLDX_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_kind == K_HLDX |=> out_valid && !out_checked); // R1
    AST_HYP_EXEC_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (acc_kind == K_HLD || acc_kind == K_HST) && pte_x |=> !out_checked); // R2
    AST_HYP_FLAG_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (acc_kind == K_HLD || acc_kind == K_HST) && hstat[HS_CFLAG] |=> !out_checked); // R3
    AST_MOD_FLAG_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_kind <= K_STORE && cur_priv == PRIV_M && mstat[MS_MPRV] && mstat[MS_CFLAG]
        |=> !out_checked); // R5
    AST_HU_GUEST_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (acc_kind == K_HLD || acc_kind == K_HST) && !hstat[HS_SPVP] &&
        cur_priv == PRIV_U && !cur_virt |=> out_mode == $past(hstat[HS_VUM_L+1:HS_VUM_L])); // R6
    AST_ZERO_MODE_UNCHECKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_mode == 2'b00 |-> !out_checked); // R7
    AST_XCPT_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        xcpt_valid |-> out_checked && xcpt_tval == XLEN'(MISMATCH_TVAL)); // R8
    AST_HYP_XCPT_GVA: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (acc_kind == K_HLD || acc_kind == K_HST) |=> !xcpt_valid || xcpt_gva); // R8
    AST_XCPT_FROM_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        xcpt_valid |-> $past(acc_valid && tag_mismatch)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !xcpt_valid && !out_checked); // R9
endmodule

bind tagchk_qual tagchk_qual_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_tagchk_qual.sv
module sim_tagchk_qual;
    localparam int XLEN = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic [2:0] acc_kind = '0;
    logic [1:0] cur_priv = '0;
    logic cur_virt = 1'b0;
    logic [XLEN-1:0] mstat = '0, hstat = '0;
    logic pte_x = 1'b0, pte_mtag = 1'b0, tag_mismatch = 1'b0;
    logic [1:0] mode_m = '0, mode_s = '0, mode_u = '0, mode_vs = '0, mode_vu = '0;
    logic out_valid, out_checked, xcpt_valid, xcpt_gva, hflag_we, mflag_we, flag_val;
    logic [1:0] out_mode;
    logic [XLEN-1:0] xcpt_cause, xcpt_tval;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    tagchk_qual #(.XLEN(XLEN)) u0 (.*);

    // expected outputs for the access sampled at the last rising edge
    logic e_val, e_chk, e_xc, e_gva, e_hwe, e_mwe, e_fv;
    logic [1:0] e_mode;
    string e_tag;

    function automatic void refmodel(output logic chk, output logic [1:0] md, output logic gva,
                                     output logic hwe, output logic mwe, output string tag);
        int ep; bit ev; bit hyp; bit modp;
        hyp  = (acc_kind == 2 || acc_kind == 3 || acc_kind == 4);
        modp = !hyp && cur_priv == 3 && mstat[17];
        if (hyp) begin ev = 1; ep = hstat[8] ? 1 : 0; end
        else if (modp) begin ep = mstat[12:11]; ev = mstat[39] && ep != 3; end
        else begin ep = cur_priv; ev = cur_virt; end
        md = 2'b00;
        if (ev && ep == 1) md = mode_vs;
        else if (ev && ep == 0) md = (hyp && cur_priv == 0 && !cur_virt) ? hstat[51:50] : mode_vu;
        else if (!ev && ep == 3) md = mode_m;
        else if (!ev && ep == 1) md = mode_s;
        else if (!ev && ep == 0) md = mode_u;
        gva = ev;
        hwe = acc_kind == 4;
        mwe = modp && mstat[19] && acc_kind == 0;
        chk = 1;
        tag = (hyp && ev && ep == 0) ? "R6" : "R7";
        if (modp) tag = "R4";
        if (acc_kind == 4) begin chk = 0; tag = "R1"; end
        else if (hyp && pte_x) begin chk = 0; tag = "R2"; end
        else if (hyp && hstat[10]) begin chk = 0; tag = "R3"; end
        else if (modp && mstat[40] && acc_kind <= 1) begin chk = 0; tag = "R5"; end
        else if (modp && pte_x && acc_kind == 0) begin chk = 0; tag = "R4"; end
        if (acc_kind > 4) chk = 0;
        if (md == 2'b00) chk = 0;
        if (chk && tag_mismatch) tag = {tag, "/R8"};
    endfunction

    always @(posedge clk) begin
        logic c, g, h, m; logic [1:0] md; string t;
        if (!rst_n || !acc_valid) begin
            e_val <= 0; e_chk <= 0; e_mode <= 0; e_xc <= 0; e_gva <= 0;
            e_hwe <= 0; e_mwe <= 0; e_fv <= 0; e_tag <= rst_n ? "R9" : "R10";
        end else begin
            refmodel(c, md, g, h, m, t);
            e_val <= 1; e_chk <= c; e_mode <= md; e_xc <= c && tag_mismatch;
            e_gva <= c && tag_mismatch && g; e_hwe <= h; e_mwe <= m;
            e_fv <= (h || m) && pte_mtag && pte_x; e_tag <= t;
        end
    end

    task automatic cmp(string name, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", e_tag, name, act, exp, $time);
        end
    endtask

    bit armed = 0;
    always @(negedge clk) if (armed) begin
        cmp("out_valid", XLEN'(out_valid), XLEN'(e_val));
        cmp("out_checked", XLEN'(out_checked), XLEN'(e_chk));
        cmp("out_mode", XLEN'(out_mode), XLEN'(e_mode));
        cmp("xcpt_valid", XLEN'(xcpt_valid), XLEN'(e_xc));
        cmp("xcpt_cause", xcpt_cause, e_xc ? XLEN'(18) : '0);
        cmp("xcpt_tval", xcpt_tval, e_xc ? XLEN'(4) : '0);
        cmp("xcpt_gva", XLEN'(xcpt_gva), XLEN'(e_gva));
        cmp("hflag_we", XLEN'(hflag_we), XLEN'(e_hwe));
        cmp("mflag_we", XLEN'(mflag_we), XLEN'(e_mwe));
        cmp("flag_val", XLEN'(flag_val), XLEN'(e_fv));
    end

    task automatic put(input logic [2:0] k, input logic [1:0] p, input logic v,
                       input logic x, input logic mt, input logic mm);
        @(negedge clk);
        acc_valid = 1; acc_kind = k; cur_priv = p; cur_virt = v;
        pte_x = x; pte_mtag = mt; tag_mismatch = mm;
    endtask

    task automatic gap();
        @(negedge clk);
        acc_valid = 0; tag_mismatch = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        mode_m = 2'b01; mode_s = 2'b10; mode_u = 2'b11; mode_vs = 2'b01; mode_vu = 2'b10;
        repeat (3) @(negedge clk);
        armed = 1;                                   // R10 reset state checked here
        @(negedge clk); rst_n = 1;
        // R1 instruction-reading hypervisor load, flag value both ways
        put(3'd4, 2'd1, 0, 1, 1, 1);
        put(3'd4, 2'd0, 0, 0, 1, 1);
        // R2 executable guest leaf, load and store
        put(3'd2, 2'd1, 0, 1, 0, 1);
        put(3'd3, 2'd1, 0, 1, 0, 1);
        // R3 guest flag set, then clear with VS effective privilege and mismatch (R8)
        hstat[10] = 1; put(3'd2, 2'd1, 0, 0, 0, 1);
        hstat[10] = 0; hstat[8] = 1; put(3'd3, 2'd1, 0, 0, 0, 1);
        // R6 U-issued vs S-issued guest user access
        hstat[8] = 0; hstat[51:50] = 2'b01; put(3'd2, 2'd0, 0, 0, 0, 1);
        put(3'd2, 2'd1, 0, 0, 0, 1);
        hstat[51:50] = 2'b00; put(3'd3, 2'd0, 0, 0, 0, 1);
        // R4 privilege modification: load with exec leaf, store with exec leaf
        mstat[17] = 1; mstat[12:11] = 2'd1;
        put(3'd0, 2'd3, 0, 1, 1, 1);
        put(3'd1, 2'd3, 0, 1, 1, 1);
        mstat[39] = 1; mstat[12:11] = 2'd0; put(3'd1, 2'd3, 0, 0, 0, 1);
        put(3'd0, 2'd1, 0, 1, 0, 1);                  // not in M: no modification
        // R5 machine flag, and MXR flag-write
        mstat[40] = 1; put(3'd1, 2'd3, 0, 0, 0, 1);
        mstat[19] = 1; put(3'd0, 2'd3, 0, 1, 1, 0);
        mstat = '0;
        // R7 plain accesses, zero mode
        put(3'd0, 2'd3, 0, 0, 0, 1);
        put(3'd1, 2'd0, 1, 0, 0, 1);
        mode_s = 2'b00; put(3'd0, 2'd1, 0, 0, 0, 1);
        put(3'd0, 2'd2, 0, 0, 0, 1);
        mode_s = 2'b10;
        // R9 back-to-back faults then idle
        put(3'd0, 2'd1, 0, 0, 0, 1);
        put(3'd0, 2'd1, 0, 0, 0, 1);
        gap(); gap();
        // mixed patterns
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            acc_valid = ($urandom % 5) != 0;
            acc_kind = 3'($urandom % 6); cur_priv = 2'($urandom);
            cur_virt = 1'($urandom); pte_x = 1'($urandom); pte_mtag = 1'($urandom);
            tag_mismatch = 1'($urandom);
            mstat = '0; hstat = '0;
            mstat[17] = 1'($urandom); mstat[19] = 1'($urandom); mstat[12:11] = 2'($urandom);
            mstat[39] = 1'($urandom); mstat[40] = ($urandom % 4) == 0;
            hstat[8] = 1'($urandom); hstat[10] = ($urandom % 4) == 0; hstat[51:50] = 2'($urandom);
            mode_m = 2'($urandom); mode_s = 2'($urandom); mode_u = 2'($urandom);
            mode_vs = 2'($urandom); mode_vu = 2'($urandom);
            if (i % 500 == 0) rst_n = 0; else rst_n = 1;
        end
        gap(); gap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule